// File: doc/BRIEF.md
# Successive approximation control register

This block sequences one successive approximation conversion and collects the decided bits into a parallel word. An active-low synchronous start loads a trial pattern: the most significant bit goes LOW as the trial marker and every lower bit goes HIGH. On each later clock the LOW marker moves one place toward the least significant bit. The place it leaves is filled with the serial decision bit presented on `d_i`. In normal use that bit comes from an external comparator, which compares the analog input against a DAC driven by the word.

A hidden stage below the least significant bit takes the marker after the last bit has been decided. That stage drives the active-low completion flag, which falls on the same edge that stores the final bit. The word then holds until the next start. A separate flip-flop gives a one-clock registered copy of the serial input. With its input tied to the register's own outputs, the same block also works as a serial-to-parallel converter or as a ring-style sequencer.

Top module: `sar_ctrl_reg`

## Requirements
- R1: While `rst_ni` is LOW, `q_o` is all ones, `cc_no` is HIGH and `qd_o` is LOW.
- R2: A rising clock edge with `start_ni` LOW sets `q_o[W-1]` LOW, sets every other bit of `q_o` HIGH and sets `cc_no` HIGH.
- R3: On the k-th rising edge after a start edge (k = 1..W), with start held HIGH, `q_o[W-k]` takes the value of `d_i` and `q_o[W-k-1]`, if it exists, goes LOW. All other bits keep their values.
- R4: The first serial bit after start lands in bit W-1, the second in bit W-2, and so on down to bit 0. With a comparator feeding `d_i`, the final word equals the comparator's target.
- R5: `cc_no` falls on exactly the W-th rising edge after the start edge, which is the edge that stores bit 0. Before that edge it stays HIGH.
- R6: Once `cc_no` is LOW, further edges with `start_ni` HIGH leave `q_o` unchanged and keep `cc_no` LOW, whatever the value of `d_i`.
- R7: Start takes priority. A start edge in the middle of a conversion reloads the trial pattern and returns `cc_no` HIGH at once.
- R8: On every rising edge out of reset, `qd_o` takes the value of `d_i`.
- R9: After reset and before the first start, `q_o` stays all ones and `cc_no` stays HIGH, whatever the value of `d_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active LOW |
| start_ni | input | 1 | Synchronous conversion start, active LOW |
| d_i | input | 1 | Serial decision bit |
| q_o | output | W | Parallel word; the LOW bit during a conversion is the trial marker |
| cc_no | output | 1 | Conversion complete, active LOW |
| qd_o | output | 1 | Registered copy of `d_i` |

## Verification
A marker stage that is lost, doubled or misplaced shows on `q_o` on the very next edge. A missing marker leaves no LOW trial bit below the filled bits. A doubled marker overwrites two places at once. Both make the final word differ from the comparator target after W edges. A fault in the hidden completion stage shows only through `cc_no`: the flag falls one edge early or late, or lets go during the hold phase. For that reason the bench compares every output on every clock against its own model, and the checker counts edges from start.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  parameter int unsigned SAR_W = 8;

  // trial pattern loaded by start: MSB low, rest high
  function automatic logic [SAR_W-1:0] trial_init();
    logic [SAR_W-1:0] v;
    v = '1;
    v[SAR_W-1] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/sar_marker.sv
// One-hot trial position chain; stage 0 is the hidden completion stage.
module sar_marker #(
  parameter int unsigned W = sar_ctrl_pkg::SAR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_ni,
  output logic [W:0]   stage_o
);
  logic [W:0] stage_q;
  logic       busy;

  assign busy = |stage_q[W:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stage_q <= '0;
    else if (!start_ni) stage_q <= (W+1)'(1) << W;
    else if (busy)      stage_q <= stage_q >> 1;
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/sar_bits.sv
// Parallel word: each bit loads on start, captures d when trial, clears when marker arrives.
module sar_bits #(
  parameter int unsigned W = sar_ctrl_pkg::SAR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_ni,
  input  logic         d_i,
  input  logic [W:0]   stage_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] INIT = sar_ctrl_pkg::trial_init();

  logic [W:0] arrive;
  assign arrive = {1'b0, stage_i[W:1]};

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              b_q <= 1'b1;
      else if (!start_ni)       b_q <= INIT[i];
      else if (stage_i[i+1])    b_q <= d_i;
      else if (arrive[i+1])     b_q <= 1'b0;
    end
    assign q_o[i] = b_q;
  end
endmodule

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg #(
  parameter int unsigned W = sar_ctrl_pkg::SAR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_ni,
  input  logic         d_i,
  output logic [W-1:0] q_o,
  output logic         cc_no,
  output logic         qd_o
);
  logic [W:0] stage;
  logic       qd_q;

  sar_marker #(.W(W)) u_marker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_ni(start_ni),
    .stage_o (stage)
  );

  sar_bits #(.W(W)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_ni(start_ni),
    .d_i     (d_i),
    .stage_i (stage),
    .q_o     (q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qd_q <= 1'b0;
    else         qd_q <= d_i;
  end

  assign qd_o  = qd_q;
  assign cc_no = ~stage[0];
endmodule

// File: rtl/sar_ctrl_reg_chk.sv
module sar_ctrl_reg_chk #(
  parameter int unsigned W = sar_ctrl_pkg::SAR_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_ni,
  input logic         d_i,
  input logic [W-1:0] q_o,
  input logic         cc_no,
  input logic         qd_o
);
  localparam int unsigned CW = $clog2(W + 2) + 1;
  localparam int unsigned IW = $clog2(W) + 1;

  logic [CW-1:0] cnt;      // edges since start edge, saturating at W+1
  logic          armed;
  logic          fill_pend;
  logic [IW-1:0] fill_idx;
  logic          fill_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      armed     <= 1'b0;
      fill_pend <= 1'b0;
      fill_idx  <= '0;
      fill_d    <= 1'b0;
    end else begin
      armed  <= 1'b1;
      fill_d <= d_i;
      if (!start_ni) begin
        cnt       <= CW'(1);
        fill_pend <= 1'b0;
      end else begin
        fill_pend <= (cnt != '0) && (int'(cnt) <= int'(W));
        fill_idx  <= IW'(int'(W) - int'(cnt));
        if (cnt != '0 && int'(cnt) <= int'(W)) cnt <= cnt + 1'b1;
      end
    end
  end

  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !start_ni) |=> (q_o == sar_ctrl_pkg::trial_init() && cc_no));

  a_r3_bit_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_pend |-> (q_o[fill_idx] == fill_d));

  a_r5_cc_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $fell(cc_no)) |-> (int'(cnt) == int'(W) + 1));

  a_r5_cc_high_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0 && int'(cnt) <= int'(W)) |-> cc_no);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !cc_no && start_ni) |=> ($stable(q_o) && !cc_no));

  a_r8_qd_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> (qd_o == $past(d_i)));

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> (q_o == '1 && cc_no));
endmodule

bind sar_ctrl_reg sar_ctrl_reg_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_ni(start_ni),
  .d_i     (d_i),
  .q_o     (q_o),
  .cc_no   (cc_no),
  .qd_o    (qd_o)
);

// File: tb/tb_sar_ctrl_reg.sv
`timescale 1ns/1ps
module tb_sar_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       start_n = 1'b1;
  logic       d = 1'b0;
  logic [7:0] q;
  logic       cc_n;
  logic       qd;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model
  logic [7:0] exp_q;
  logic       exp_done;
  logic       exp_qd;
  int         m_fill;

  sar_ctrl_reg #(.W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .d_i(d),
    .q_o(q), .cc_no(cc_n), .qd_o(qd)
  );

  always #10 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, a, e, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q = 8'hFF; exp_done = 1'b0; exp_qd = 1'b0; m_fill = -1;
    end else begin
      exp_qd = d;
      if (!start_n) begin
        exp_q = 8'h7F; exp_done = 1'b0; m_fill = 7;
      end else if (m_fill >= 0) begin
        exp_q[m_fill] = d;
        if (m_fill > 0) exp_q[m_fill-1] = 1'b0;
        else            exp_done = 1'b1;
        m_fill--;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 word", {24'd0, q}, {24'd0, exp_q});
      chk("R5 cc", {31'd0, cc_n}, {31'd0, ~exp_done});
      chk("R8 qd", {31'd0, qd}, {31'd0, exp_qd});
    end
  end

  function automatic logic cmp(input logic [7:0] tgt);
    logic [7:0] tent;
    if (m_fill < 0) return 1'b0;
    tent = exp_q ^ 8'((16'd1 << (m_fill + 1)) - 1);
    return tent <= tgt;
  endfunction

  task automatic do_start();
    @(negedge clk); start_n = 1'b0;
    @(negedge clk); start_n = 1'b1;
    chk("R2 start word", {24'd0, q}, 32'h7F);
    chk("R2 start cc", {31'd0, cc_n}, 32'd1);
  endtask

  task automatic conv(input logic [7:0] tgt, input int abort_at);
    do_start();
    for (int k = 0; k < 8; k++) begin
      if (k == abort_at) return;
      d = cmp(tgt);
      @(negedge clk);
      if (k < 7) chk("R5 cc early", {31'd0, cc_n}, 32'd1);
    end
    chk("R4 final word", {24'd0, q}, {24'd0, tgt});
    chk("R5 cc on last bit", {31'd0, cc_n}, 32'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #44;
    chk("R1 reset word", {24'd0, q}, 32'hFF);
    chk("R1 reset cc", {31'd0, cc_n}, 32'd1);
    chk("R1 reset qd", {31'd0, qd}, 32'd0);
    rst_n = 1'b1;
    // R9 idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); d = i[0];
    end
    @(negedge clk);
    chk("R9 idle word", {24'd0, q}, 32'hFF);
    chk("R9 idle cc", {31'd0, cc_n}, 32'd1);
    // R8 explicit
    d = 1'b1; @(negedge clk);
    chk("R8 qd one", {31'd0, qd}, 32'd1);
    d = 1'b0; @(negedge clk);
    chk("R8 qd zero", {31'd0, qd}, 32'd0);
    // R3 explicit partial fill 1,0,1
    do_start();
    d = 1'b1; @(negedge clk);
    d = 1'b0; @(negedge clk);
    d = 1'b1; @(negedge clk);
    chk("R3 partial fill", {24'd0, q}, 32'hAF);
    // R7 restart mid conversion
    do_start();
    chk("R7 restart cc", {31'd0, cc_n}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      d = cmp(8'h3C); @(negedge clk);
    end
    chk("R7 result after restart", {24'd0, q}, 32'h3C);
    // R4/R5 several targets
    conv(8'h00, 8);
    conv(8'hFF, 8);
    conv(8'hA5, 8);
    conv(8'h5A, 3);
    conv(8'h81, 8);
    // R6 hold
    for (int i = 0; i < 5; i++) begin
      d = ~d; @(negedge clk);
      chk("R6 hold word", {24'd0, q}, 32'h81);
      chk("R6 hold cc", {31'd0, cc_n}, 32'd0);
    end
    // R7 restart from done clears cc
    do_start();
    for (int i = 0; i < 20; i++) begin
      conv(8'($urandom), 8);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule